// File: doc/BRIEF.md
# Doorbell Interrupt Register Bank

This block is the small control register file of a shared-memory messaging endpoint. It answers 32-bit word reads and writes inside a 256-byte window. It holds an interrupt enable mask, an interrupt cause word and a read-only endpoint number. Reading the cause word clears it. The block drives a level interrupt line whenever an enabled cause bit is set.

A write to the doorbell word asks the block to signal a remote peer on one of that peer's vectors. The block checks the request against a table that records how many vectors each peer has registered. A request that passes produces a one-cycle notify strobe that carries the peer and the vector. A request that fails is dropped without any effect. A local notification input loads the cause word with the value 1. When message-signalled mode is selected, or no interrupt pin is present, the level line stays low.

Top module: `dbell_regbank`

## Requirements
- R1: The word at offset 0x00 is the mask (read/write), 0x04 is the cause word, 0x08 returns the `localId` input zero-extended, and 0x0C is the doorbell. Read data appears on `busRdData` with `busRdValid` high in the cycle after `busRdEn`.
- R2: Reads decode all eight address bits exactly. A read of any address that is not 0x00, 0x04 or 0x08 returns 0 (0x0C and 0x05 included), and such a read does not clear the cause word.
- R3: A read of 0x04 returns the cause value and clears the cause word in the same edge. `irqLevel` is low from the next cycle unless a new cause arrives.
- R4: `irqLevel` is high exactly when (cause AND mask) is non-zero, and it follows a mask or cause write from the cycle after the write.
- R5: While `msiMode` is 1 or `pinPresent` is 0, `irqLevel` is 0.
- R6: On writes, address bits 1:0 are ignored. For example, a write to 0x07 writes the cause word and a write to 0x01 writes the mask.
- R7: A doorbell write takes the peer from data bits 31:16 and the vector from bits 7:0, and ignores bits 15:8. An accepted doorbell raises `notifyValid` for exactly one cycle, in the cycle after the write, with `notifyPeer` and `notifyVec` set to the request.
- R8: A doorbell is dropped (no strobe) if the peer is at or above PEER_MAX, or if the vector is at or above that peer's table count.
- R9: The peer table entry `tblWrPeer` takes `tblWrCnt` on a clock with `tblWrEn`. All entries are 0 after reset.
- R10: A `localEvent` pulse sets the cause word to exactly 1, replacing its previous value. A bus cause write in the same cycle takes priority over the event. An event takes priority over a clearing read in the same cycle, and that read still returns the old value.
- R11: Reset sets the mask and the cause word to 0 and holds `notifyValid` and `busRdValid` low.
- R12: Writes to 0x08 and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| busWrEn | input | 1 | word write request |
| busRdEn | input | 1 | word read request |
| busAddr | input | 8 | byte address in the window |
| busWrData | input | 32 | write data |
| busRdData | output | 32 | read data, one cycle after request |
| busRdValid | output | 1 | read data valid |
| localId | input | 16 | endpoint number returned at 0x08 |
| msiMode | input | 1 | message-signalled mode, silences level line |
| pinPresent | input | 1 | level interrupt pin configured |
| localEvent | input | 1 | local notification pulse |
| tblWrEn | input | 1 | peer table write enable |
| tblWrPeer | input | 4 | peer table index |
| tblWrCnt | input | 9 | registered vector count for that peer |
| irqLevel | output | 1 | level interrupt |
| notifyValid | output | 1 | one-cycle doorbell strobe |
| notifyPeer | output | 16 | destination peer |
| notifyVec | output | 8 | destination vector |

## Verification
Register writes, the local event and table loads take effect at the edge that samples them. The interrupt level is a combinational function of the registers, so it is correct one cycle after the stimulus. Read data and `notifyValid` pass through one output register each, so both are due in that same cycle and the strobe must fall one cycle later. The bench drives inputs on the falling edge and samples on the next falling edge, which places every check in the first cycle that its result is due. The checks for the pin and mode gating are made a short delay after the control input changes, because that path has no register.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam logic [5:0] WORD_MASK   = 6'd0;
  localparam logic [5:0] WORD_CAUSE  = 6'd1;
  localparam logic [5:0] WORD_ID     = 6'd2;
  localparam logic [5:0] WORD_BELL   = 6'd3;

  typedef struct packed {
    logic wrMask;
    logic wrCause;
    logic wrBell;
    logic rdMask;
    logic rdCause;
    logic rdId;
  } regStrobe_t;
endpackage

// File: rtl/dbell_ctrl.sv
module dbell_ctrl
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              rdAligned;
  logic [WORD_W-1:0] maskIdx, causeIdx, idIdx, bellIdx;

  assign maskIdx  = WORD_W'(WORD_MASK);
  assign causeIdx = WORD_W'(WORD_CAUSE);
  assign idIdx    = WORD_W'(WORD_ID);
  assign bellIdx  = WORD_W'(WORD_BELL);

  // writes drop the byte lane bits, reads need them zero
  assign wordIdx   = busAddr[ADDR_W-1:2];
  assign rdAligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobe = '0;
    if (busWrEn) begin
      strobe.wrMask  = (wordIdx == maskIdx);
      strobe.wrCause = (wordIdx == causeIdx);
      strobe.wrBell  = (wordIdx == bellIdx);
    end
    if (busRdEn && rdAligned) begin
      strobe.rdMask  = (wordIdx == maskIdx);
      strobe.rdCause = (wordIdx == causeIdx);
      strobe.rdId    = (wordIdx == idIdx);
    end
  end
endmodule

// File: rtl/dbell_dpath.sv
module dbell_dpath
  import dbell_pkg::*;
#(
  parameter int PEER_MAX = 16,
  parameter int PEER_W   = 4,
  parameter int CNT_W    = 9,
  parameter int ID_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  input  logic [ID_W-1:0]   localId,
  input  logic              msiMode,
  input  logic              pinPresent,
  input  logic              localEvent,
  input  logic              tblWrEn,
  input  logic [PEER_W-1:0] tblWrPeer,
  input  logic [CNT_W-1:0]  tblWrCnt,
  output logic [31:0]       busRdData,
  output logic              busRdValid,
  output logic              irqLevel,
  output logic              notifyValid,
  output logic [15:0]       notifyPeer,
  output logic [7:0]        notifyVec
);
  localparam logic [15:0] PEER_LIM = 16'(PEER_MAX);

  logic [31:0] maskQ, causeQ, causeNext;
  logic [CNT_W-1:0] cntTable [PEER_MAX];

  // peer vector count table, one register per entry
  for (genvar p = 0; p < PEER_MAX; p++) begin : g_peer
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntTable[p] <= '0;
      end else if (tblWrEn && (tblWrPeer == PEER_W'(p))) begin
        cntTable[p] <= tblWrCnt;
      end
    end
  end

  // cause word: bus write, then local event, then clearing read
  always_comb begin
    causeNext = causeQ;
    if (strobe.wrCause) begin
      causeNext = busWrData;
    end else if (localEvent) begin
      causeNext = 32'd1;
    end else if (strobe.rdCause) begin
      causeNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      causeQ <= '0;
    end else begin
      if (strobe.wrMask) maskQ <= busWrData;
      causeQ <= causeNext;
    end
  end

  // read path, one register stage
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (strobe.rdMask)  rdMux = maskQ;
    if (strobe.rdCause) rdMux = causeQ;
    if (strobe.rdId)    rdMux = 32'(localId);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData  <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= busRdEn;
      busRdData  <= busRdEn ? rdMux : '0;
    end
  end

  // doorbell validation
  logic [15:0]      bellPeer;
  logic [7:0]       bellVec;
  logic             peerInRange, bellOk;
  logic [CNT_W-1:0] peerCnt;

  assign bellPeer    = busWrData[31:16];
  assign bellVec     = busWrData[7:0];
  assign peerInRange = (bellPeer < PEER_LIM);
  assign peerCnt     = peerInRange ? cntTable[bellPeer[PEER_W-1:0]] : '0;
  assign bellOk      = strobe.wrBell && peerInRange &&
                       (CNT_W'(bellVec) < peerCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      notifyValid <= 1'b0;
      notifyPeer  <= '0;
      notifyVec   <= '0;
    end else begin
      notifyValid <= bellOk;
      if (bellOk) begin
        notifyPeer <= bellPeer;
        notifyVec  <= bellVec;
      end
    end
  end

  assign irqLevel = (|(causeQ & maskQ)) && pinPresent && !msiMode;
endmodule

// File: rtl/dbell_regbank.sv
module dbell_regbank
  import dbell_pkg::*;
#(
  parameter int PEER_MAX = 16,
  parameter int ADDR_W   = 8,
  parameter int ID_W     = 16,
  parameter int PEER_W   = (PEER_MAX > 1) ? $clog2(PEER_MAX) : 1,
  parameter int CNT_W    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              busRdValid,
  input  logic [ID_W-1:0]   localId,
  input  logic              msiMode,
  input  logic              pinPresent,
  input  logic              localEvent,
  input  logic              tblWrEn,
  input  logic [PEER_W-1:0] tblWrPeer,
  input  logic [CNT_W-1:0]  tblWrCnt,
  output logic              irqLevel,
  output logic              notifyValid,
  output logic [15:0]       notifyPeer,
  output logic [7:0]        notifyVec
);
  regStrobe_t strobe;

  dbell_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  dbell_dpath #(
    .PEER_MAX(PEER_MAX), .PEER_W(PEER_W), .CNT_W(CNT_W), .ID_W(ID_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busRdEn     (busRdEn),
    .busWrData   (busWrData),
    .localId     (localId),
    .msiMode     (msiMode),
    .pinPresent  (pinPresent),
    .localEvent  (localEvent),
    .tblWrEn     (tblWrEn),
    .tblWrPeer   (tblWrPeer),
    .tblWrCnt    (tblWrCnt),
    .busRdData   (busRdData),
    .busRdValid  (busRdValid),
    .irqLevel    (irqLevel),
    .notifyValid (notifyValid),
    .notifyPeer  (notifyPeer),
    .notifyVec   (notifyVec)
  );
endmodule

// File: rtl/dbell_regbank_chk.sv
module dbell_regbank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic              busRdValid,
  input logic              msiMode,
  input logic              pinPresent,
  input logic              localEvent,
  input logic              irqLevel,
  input logic              notifyValid,
  input logic [15:0]       notifyPeer,
  input logic [7:0]        notifyVec
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid); // R1

  AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid); // R1

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(4) && !busWrEn && !localEvent)
      |=> !irqLevel); // R3

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[ADDR_W-1:2] == '0 && busWrData == '0 && !localEvent)
      |=> !irqLevel); // R4

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (msiMode || !pinPresent) |-> !irqLevel); // R5

  AST_BELL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> ($past(busWrEn) && $past(busAddr[ADDR_W-1:2]) == 3)); // R7

  AST_BELL_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> (notifyPeer == $past(busWrData[31:16]) &&
                     notifyVec == $past(busWrData[7:0]))); // R7
endmodule

bind dbell_regbank dbell_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busWrEn     (busWrEn),
  .busRdEn     (busRdEn),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .busRdValid  (busRdValid),
  .msiMode     (msiMode),
  .pinPresent  (pinPresent),
  .localEvent  (localEvent),
  .irqLevel    (irqLevel),
  .notifyValid (notifyValid),
  .notifyPeer  (notifyPeer),
  .notifyVec   (notifyVec)
);

// File: tb/sim_dbell_regbank.sv
module sim_dbell_regbank;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn, busRdEn;
  logic [7:0]  busAddr;
  logic [31:0] busWrData, busRdData;
  logic        busRdValid;
  logic [15:0] localId;
  logic        msiMode, pinPresent, localEvent;
  logic        tblWrEn;
  logic [3:0]  tblWrPeer;
  logic [8:0]  tblWrCnt;
  logic        irqLevel, notifyValid;
  logic [15:0] notifyPeer;
  logic [7:0]  notifyVec;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  dbell_regbank u0 (.*);

  // vector: op[78:77] addr[76:69] data[68:37] expRd[36:5] expIrq[4] req[3:0]
  // op 0 = write, 1 = read, 2 = local event
  localparam int NV = 20;
  localparam logic [78:0] VEC [NV] = '{
    {2'd0, 8'h00, 32'h5, 32'h0, 1'b0, 4'd4},   // R4 mask 0b101
    {2'd1, 8'h00, 32'h0, 32'h5, 1'b0, 4'd1},   // R1 read mask
    {2'd0, 8'h04, 32'h4, 32'h0, 1'b1, 4'd4},   // R4 4&5 -> irq
    {2'd1, 8'h04, 32'h0, 32'h4, 1'b0, 4'd3},   // R3 read returns, clears
    {2'd1, 8'h04, 32'h0, 32'h0, 1'b0, 4'd3},   // R3 second read zero
    {2'd2, 8'h00, 32'h0, 32'h0, 1'b1, 4'd10},  // R10 event -> cause 1
    {2'd1, 8'h04, 32'h0, 32'h1, 1'b0, 4'd10},  // R10 cause holds 1
    {2'd0, 8'h04, 32'h6, 32'h0, 1'b1, 4'd4},   // R4 6&5
    {2'd2, 8'h00, 32'h0, 32'h0, 1'b1, 4'd10},  // R10 overwrite to 1
    {2'd1, 8'h04, 32'h0, 32'h1, 1'b0, 4'd10},  // R10 not OR'd
    {2'd0, 8'h07, 32'h2, 32'h0, 1'b0, 4'd6},   // R6 hits cause, 2&5=0
    {2'd1, 8'h07, 32'h0, 32'h0, 1'b0, 4'd2},   // R2 unaligned read 0
    {2'd1, 8'h04, 32'h0, 32'h2, 1'b0, 4'd2},   // R2 no clear; R6 value
    {2'd1, 8'h08, 32'h0, 32'h3, 1'b0, 4'd1},   // R1 id
    {2'd0, 8'h08, 32'hFFFF, 32'h0, 1'b0, 4'd12}, // R12 id write
    {2'd1, 8'h08, 32'h0, 32'h3, 1'b0, 4'd12},  // R12 id unchanged
    {2'd0, 8'h40, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd12}, // R12 unmapped
    {2'd1, 8'h00, 32'h0, 32'h5, 1'b0, 4'd12},  // R12 mask unchanged
    {2'd0, 8'h01, 32'h2, 32'h0, 1'b0, 4'd6},   // R6 mask via 0x01
    {2'd1, 8'h0C, 32'h0, 32'h0, 1'b0, 4'd2}    // R2 doorbell reads 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    busWrEn = 0; busRdEn = 0; localEvent = 0; tblWrEn = 0;
  endtask

  // drive on falling edge, sample on next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); idle(); busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); idle(); busRdEn = 1; busAddr = a;
    @(negedge clk); idle();
  endtask

  task automatic ev();
    @(negedge clk); idle(); localEvent = 1;
    @(negedge clk); idle();
  endtask

  task automatic tbl(input logic [3:0] p, input logic [8:0] c);
    @(negedge clk); idle(); tblWrEn = 1; tblWrPeer = p; tblWrCnt = c;
    @(negedge clk); idle();
  endtask

  task automatic bell(input logic [31:0] d, input logic expV, input string req);
    wr(8'h0C, d);
    check(req, {31'd0, notifyValid}, {31'd0, expV});
    if (expV) begin
      check(req, {16'd0, notifyPeer}, {16'd0, d[31:16]});
      check(req, {24'd0, notifyVec}, {24'd0, d[7:0]});
      @(negedge clk);
      check(req, {31'd0, notifyValid}, 32'd0);
    end
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 0; idle(); busAddr = 0; busWrData = 0; localId = 16'h0003;
    msiMode = 0; pinPresent = 1; tblWrPeer = 0; tblWrCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11 reset state
    check("R11", {31'd0, irqLevel}, 32'd0);
    check("R11", {31'd0, notifyValid}, 32'd0);
    rd(8'h00); check("R11", busRdData, 32'd0);
    rd(8'h04); check("R11", busRdData, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] v;
      string req;
      v = VEC[i];
      req = $sformatf("R%0d", v[3:0]);
      case (v[78:77])
        2'd0: wr(v[76:69], v[68:37]);
        2'd1: rd(v[76:69]);
        default: ev();
      endcase
      if (v[78:77] == 2'd1) begin
        check(req, busRdData, v[36:5]);
        check("R1", {31'd0, busRdValid}, 32'd1);
      end
      check(req, {31'd0, irqLevel}, {31'd0, v[4]});
    end

    // R5 gating: mask 1, cause 1 -> line high, then gated
    wr(8'h00, 32'h1); ev();
    check("R4", {31'd0, irqLevel}, 32'd1);
    msiMode = 1; #1; check("R5", {31'd0, irqLevel}, 32'd0);
    msiMode = 0; pinPresent = 0; #1; check("R5", {31'd0, irqLevel}, 32'd0);
    pinPresent = 1; #1; check("R5", {31'd0, irqLevel}, 32'd1);

    // R10 priority: event with cause write -> write wins
    @(negedge clk); idle(); busWrEn = 1; busAddr = 8'h04; busWrData = 32'h8; localEvent = 1;
    @(negedge clk); idle();
    rd(8'h04); check("R10", busRdData, 32'h8);
    // R10 event with clearing read -> read old, cause becomes 1
    wr(8'h04, 32'h10);
    @(negedge clk); idle(); busRdEn = 1; busAddr = 8'h04; localEvent = 1;
    @(negedge clk); idle();
    check("R10", busRdData, 32'h10);
    check("R10", {31'd0, irqLevel}, 32'd1);
    rd(8'h04); check("R10", busRdData, 32'h1);

    // R9 table loads, R7/R8 doorbells
    bell(32'h0002_0000, 1'b0, "R9 empty table drop");
    tbl(4'd2, 9'd4);
    tbl(4'd15, 9'd1);
    tbl(4'd0, 9'd256);
    bell(32'h0002_0003, 1'b1, "R7 last vector");
    bell(32'h0002_0004, 1'b0, "R8 vector at count");
    bell(32'h0002_FF01, 1'b1, "R7 bits 15:8 ignored");
    bell(32'h0010_0000, 1'b0, "R8 peer at limit");
    bell(32'h0005_0000, 1'b0, "R8 peer count zero");
    bell(32'h000F_0000, 1'b1, "R7 top peer");
    bell(32'h0000_00FF, 1'b1, "R9 full count");
    bell(32'h0012_0000, 1'b0, "R8 aliasing peer");
    tbl(4'd2, 9'd0);
    bell(32'h0002_0000, 1'b0, "R9 entry rewritten");

    // R11 reset mid-run
    wr(8'h00, 32'hF); ev();
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    check("R11", {31'd0, irqLevel}, 32'd0);
    rd(8'h00); check("R11", busRdData, 32'd0);
    bell(32'h000F_0000, 1'b0, "R11 table cleared");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule